// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on one output line. A write port places each byte into a holding store. In buffered mode that store is a 16-entry queue. In single mode it holds one byte. A frame engine takes the oldest stored byte as soon as it is idle and sends it out. It times every bit from an external enable that pulses at sixteen times the bit rate.

The frame format is set by a few static inputs: character length, parity and stop length. Two status outputs tell the host when the store is empty and when the whole transmitter, including the frame engine, has gone quiet. An interrupt line follows the store-empty condition while its enable is set. Changing the store mode discards any bytes that have not yet been sent.

Top module: `txq_uart`

## Requirements
- R1: While `rst_n` is low, `txd` is 1, `hold_empty` is 1, `tx_empty` is 1, and with `thre_ie` low `irq` is 0.
- R2: Every frame bit, starting with the start bit, lasts exactly 16 pulses of `tick16`.
- R3: A frame is a 0 start bit, then the data bits with bit 0 first, then the parity bit if enabled, then stop bits at 1.
- R4: `char_len` selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Written bits above that count are not sent.
- R5: With `par_en` high, one parity bit follows the data. With `par_odd` 0 the count of ones across the sent data bits and the parity bit is even. With `par_odd` 1 that count is odd. Unsent upper bits do not take part.
- R6: With `stop2` low the stop period is 16 ticks. With `stop2` high it is 32 ticks, or 24 ticks when the length is 5 bits.
- R7: With `fifo_en` high, up to 16 bytes wait in order behind the frame in progress and are sent in write order. A write that arrives while 16 are waiting is dropped, and the stored bytes stay unchanged.
- R8: With `fifo_en` low, the store holds one byte. `hold_empty` falls on the write and rises in the cycle that byte moves into the frame engine. A write while the byte is still held is dropped.
- R9: `tx_empty` is 1 only when the store is empty and no frame is in progress. It rises on the tick that ends the last stop period.
- R10: `irq` is high exactly when `thre_ie` is high and `hold_empty` is high.
- R11: In a cycle where `fifo_en` differs from its value in the previous cycle, all unsent stored bytes are discarded, along with any write in that cycle. A frame already in progress still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 selects the single holding byte |
| char_len | input | 2 | Data bit count minus 5 |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop2 | input | 1 | Long stop period select |
| thre_ie | input | 1 | Interrupt enable for the store-empty condition |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial line, idles at 1 |
| hold_empty | output | 1 | Store holds no unsent byte |
| tx_empty | output | 1 | Store empty and frame engine idle |
| irq | output | 1 | Store-empty interrupt, active high |

## Verification
A wrong fill count or pointer becomes visible at the line as a missing, repeated or reordered character. This appears as soon as the affected byte reaches the frame engine, at most one frame per queued byte later. A wrong tick counter or wrong stop length moves the rise of `tx_empty` away from the tick where the last stop period ends, so a frame one tick too long or too short is seen in the same frame. Wrong frame contents, such as wrong parity, leaked upper bits or a wrong bit order, are seen in mid-bit samples of the frame in which the error occurs.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;
  typedef enum logic [1:0] {
    LEN5 = 2'd0,
    LEN6 = 2'd1,
    LEN7 = 2'd2,
    LEN8 = 2'd3
  } len_e;

  localparam int MIN_BITS = 5;
  localparam int MAX_BITS = 8;
  // start + 8 data + parity + two stop slots
  localparam int FRAME_W  = 1 + MAX_BITS + 1 + 2;
endpackage

// File: rtl/txq_fifo.sv
`timescale 1ns/1ps
module txq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic             cap_one,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, do_push, do_pop;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = cap_one ? (cnt_q != '0) : (cnt_q == CNT_W'(DEPTH));
    do_push = push & ~full & ~flush;
    do_pop  = pop & ~empty & ~flush;

    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push)
        wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
      if (do_pop)
        rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; only the pointers and count qualify it
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/txq_frame.sv
`timescale 1ns/1ps
module txq_frame #(
  parameter int TPB     = 16,
  parameter int FRAME_W = txq_pkg::FRAME_W,
  parameter int CNT_W   = 8
) (
  input  logic [7:0]         data,
  input  txq_pkg::len_e      len,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               stop2,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   last
);
  int   nbits;
  int   stop_ticks;
  int   total;
  logic par;

  always_comb begin
    nbits = txq_pkg::MIN_BITS + int'(len);
    frame = '1;
    frame[0] = 1'b0;
    par = par_odd;
    for (int i = 0; i < txq_pkg::MAX_BITS; i++) begin
      if (i < nbits) begin
        frame[i + 1] = data[i];
        par = par ^ data[i];
      end
    end
    if (par_en) frame[nbits + 1] = par;

    if (!stop2)                           stop_ticks = TPB;
    else if (nbits == txq_pkg::MIN_BITS)  stop_ticks = TPB + TPB / 2;
    else                                  stop_ticks = 2 * TPB;
    total = TPB * (1 + nbits + (par_en ? 1 : 0)) + stop_ticks;
    last  = CNT_W'(total - 1);
  end
endmodule

// File: rtl/txq_shift.sv
`timescale 1ns/1ps
module txq_shift #(
  parameter int TPB     = 16,
  parameter int FRAME_W = txq_pkg::FRAME_W,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   last_in,
  output logic               busy,
  output logic               txd
);
  localparam int TPB_LOG = $clog2(TPB);

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, last_q, last_d;
  logic [FRAME_W-1:0] frame_q, frame_d;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    frame_d = frame_q;
    if (load && !busy_q) begin
      busy_d  = 1'b1;
      cnt_d   = '0;
      last_d  = last_in;
      frame_d = frame_in;
    end else if (busy_q && tick) begin
      if (cnt_q == last_q) busy_d = 1'b0;
      else                 cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      last_q  <= '0;
      frame_q <= '1;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      frame_q <= frame_d;
    end
  end

  // the upper counter bits select the frame slot; idle line is mark
  assign txd  = busy_q ? frame_q[cnt_q[CNT_W-1:TPB_LOG]] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/txq_uart.sv
`timescale 1ns/1ps
module txq_uart #(
  parameter int DEPTH = 16,
  parameter int TPB   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       fifo_en,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop2,
  input  logic       thre_ie,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty,
  output logic       irq
);
  localparam int FRAME_W = txq_pkg::FRAME_W;
  localparam int CNT_W   = $clog2(TPB * FRAME_W);
  localparam int FILL_W  = $clog2(DEPTH + 1);

  logic               mode_q;
  logic               flush, load, busy, empty;
  logic [7:0]         head;
  logic [FILL_W-1:0]  fill;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;
  end

  always_comb begin
    flush = fifo_en ^ mode_q;
    load  = ~busy & ~empty & ~flush;
  end

  txq_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .push    (wr_en),
    .pop     (load),
    .cap_one (~mode_q),
    .din     (wr_data),
    .dout    (head),
    .count   (fill),
    .empty   (empty)
  );

  txq_frame #(.TPB(TPB), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
    .data    (head),
    .len     (txq_pkg::len_e'(char_len)),
    .par_en  (par_en),
    .par_odd (par_odd),
    .stop2   (stop2),
    .frame   (frame),
    .last    (last)
  );

  txq_shift #(.TPB(TPB), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .load     (load),
    .frame_in (frame),
    .last_in  (last),
    .busy     (busy),
    .txd      (txd)
  );

  assign hold_empty = empty;
  assign tx_empty   = empty & ~busy;
  assign irq        = thre_ie & empty;
endmodule

// File: rtl/txq_uart_chk.sv
`timescale 1ns/1ps
module txq_uart_chk #(
  parameter int DEPTH = 16,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txd,
  input logic              hold_empty,
  input logic              tx_empty,
  input logic              irq,
  input logic              thre_ie,
  input logic              fifo_en,
  input logic              busy,
  input logic [FILL_W-1:0] fill
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_mark_R1: assert (txd == 1'b1 && hold_empty == 1'b1);
    end
  end

  assert_idle_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  assert_empty_implies_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (hold_empty && !busy));

  assert_irq_needs_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> hold_empty);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !thre_ie |-> !irq);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH));

  assert_single_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && $past(!fifo_en)) |-> (fill <= FILL_W'(1)));
endmodule

bind txq_uart txq_uart_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .txd        (txd),
  .hold_empty (hold_empty),
  .tx_empty   (tx_empty),
  .irq        (irq),
  .thre_ie    (thre_ie),
  .fifo_en    (fifo_en),
  .busy       (busy),
  .fill       (fill)
);

// File: tb/sim_txq_uart.sv
`timescale 1ns/1ps
module sim_txq_uart;
  logic       clk = 1'b0;
  logic       rst_n, tick16, fifo_en, par_en, par_odd, stop2, thre_ie, wr_en;
  logic [1:0] char_len;
  logic [7:0] wr_data;
  logic       txd, hold_empty, tx_empty, irq;

  always #10 clk = ~clk;

  txq_uart u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .fifo_en(fifo_en),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
    .thre_ie(thre_ie), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int frames = 0;
  bit tick_on = 1'b0;
  bit done = 1'b0;
  logic [7:0] eq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int frame_ticks(input int n, input int p, input bit s2);
    int st;
    st = !s2 ? 16 : (n == 5 ? 24 : 32);
    return 16 * (1 + n + p) + st;
  endfunction

  // tick pulse every fourth cycle, changed at the falling edge
  initial begin
    int ph = 0;
    tick16 = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      tick16 = tick_on && (ph == 0);
    end
  end

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // line monitor: samples after each edge, mid-bit on tick counts 16*i+8
  bit         act = 1'b0;
  bit         early;
  int         k;
  logic [15:0] samp;

  task automatic close_frame();
    int n, p, t;
    logic [7:0] d, m, got;
    logic pe;
    bit stops_ok;
    n = 5 + int'(char_len);
    p = par_en ? 1 : 0;
    t = frame_ticks(n, p, stop2);
    frames++;
    if (eq.size() == 0) begin
      chk(1'b0, "R7", "unexpected frame", 1, 0);
      return;
    end
    d = eq.pop_front();
    m = d & 8'((1 << n) - 1);
    got = '0;
    for (int i = 0; i < n; i++) got[i] = samp[1 + i];
    chk(samp[0] == 1'b0, "R3", "start bit", int'(samp[0]), 0);
    chk(got == m, "R4 R3", "data bits", int'(got), int'(m));
    if (p == 1) begin
      pe = (^m) ^ par_odd;
      chk(samp[1 + n] == pe, "R5", "parity bit", int'(samp[1 + n]), int'(pe));
    end
    stops_ok = 1'b1;
    for (int i = 1 + n + p; 16 * i + 8 < t; i++)
      if (samp[i] != 1'b1) stops_ok = 1'b0;
    chk(stops_ok, "R6 R3", "stop level", int'(stops_ok), 1);
    if (eq.size() == 0)
      chk(tx_empty && !early, "R2 R6 R9", "frame end tick", int'(tx_empty && !early), 1);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (!rst_n) act = 1'b0;
    else if (!act) begin
      if (txd == 1'b0) begin
        act = 1'b1;
        k = 0;
        samp = '1;
        early = 1'b0;
      end
    end else if (tick16) begin
      int t;
      t = frame_ticks(5 + int'(char_len), par_en ? 1 : 0, stop2);
      k++;
      if (k % 16 == 8 && k / 16 < 16) samp[k / 16] = txd;
      if (k < t && tx_empty) early = 1'b1;
      if (k == t) begin
        close_frame();
        act = 1'b0;
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (!(tx_empty && !act) && t < 30000) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    int f0;
    int idx = 0;
    rst_n = 1'b0;
    fifo_en = 1'b0; char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;
    stop2 = 1'b0; thre_ie = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1", "hold_empty in reset", int'(hold_empty), 1);
    chk(tx_empty == 1'b1, "R1", "tx_empty in reset", int'(tx_empty), 1);
    chk(irq == 1'b0, "R1", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    fifo_en = 1'b1;
    repeat (3) @(negedge clk);

    // format sweep: every length, parity mode and stop length, two frames each
    tick_on = 1'b1;
    for (int ln = 0; ln < 4; ln++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int s = 0; s < 2; s++) begin
          logic [7:0] a, b;
          char_len = 2'(ln);
          par_en = (pm != 0);
          par_odd = (pm == 2);
          stop2 = s[0];
          a = 8'(idx * 53 + 8'hC3);
          b = 8'(idx * 29 + 8'h5A);
          idx++;
          eq.push_back(a);
          eq.push_back(b);
          wr(a);
          wr(b);
          wait_idle();
        end
      end
    end

    // queue depth and drop of the overflowing write (R7), interrupt (R10)
    char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0; stop2 = 1'b0;
    tick_on = 1'b0;
    repeat (4) @(negedge clk);
    f0 = frames;
    for (int i = 0; i < 18; i++) begin
      logic [7:0] v;
      v = 8'(8'h10 + i * 7);
      if (i < 17) eq.push_back(v);
      wr(v);
    end
    chk(hold_empty == 1'b0, "R7", "queue holds bytes", int'(hold_empty), 0);
    thre_ie = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R10", "irq while queue busy", int'(irq), 0);
    tick_on = 1'b1;
    wait_idle();
    chk(frames - f0 == 17, "R7", "frames from full queue", frames - f0, 17);
    chk(eq.size() == 0, "R7", "expected bytes left", eq.size(), 0);
    chk(irq == 1'b1, "R10", "irq when empty and enabled", int'(irq), 1);
    thre_ie = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R10", "irq masked", int'(irq), 0);

    // single holding byte (R8)
    tick_on = 1'b0;
    fifo_en = 1'b0;
    repeat (3) @(negedge clk);
    f0 = frames;
    eq.push_back(8'h3C);
    wr(8'h3C);
    chk(hold_empty == 1'b0, "R8", "held before transfer", int'(hold_empty), 0);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R8", "empty after transfer", int'(hold_empty), 1);
    chk(tx_empty == 1'b0, "R9", "tx_empty while sending", int'(tx_empty), 0);
    eq.push_back(8'h81);
    wr(8'h81);
    chk(hold_empty == 1'b0, "R8", "second byte held", int'(hold_empty), 0);
    wr(8'hE7);
    tick_on = 1'b1;
    wait_idle();
    chk(frames - f0 == 2, "R8", "frames in single mode", frames - f0, 2);

    // mode change discards unsent bytes (R11)
    fifo_en = 1'b1;
    tick_on = 1'b0;
    repeat (3) @(negedge clk);
    f0 = frames;
    eq.push_back(8'h96);
    wr(8'h96);
    wr(8'h11);
    wr(8'h22);
    chk(hold_empty == 1'b0, "R11", "bytes waiting", int'(hold_empty), 0);
    fifo_en = 1'b0;
    @(negedge clk);
    chk(hold_empty == 1'b1, "R11", "discarded on change", int'(hold_empty), 1);
    fifo_en = 1'b1;
    repeat (2) @(negedge clk);
    tick_on = 1'b1;
    wait_idle();
    chk(frames - f0 == 1, "R11", "only running frame sent", frames - f0, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule